// File: doc/BRIEF.md
# Maskable Status Alert Aggregator

This block gathers latched fault bits for a set of power channels (pages) and drives one shared active-low alert line. Each page has several detailed status registers: output voltage, output current and temperature by default. Every detailed bit has its own mask bit. A fault-set pulse latches bits into one register of one page. Software clears a latched bit by writing a one to it. A single clear command wipes every latched bit at once.

The detailed registers roll up into a per-page summary word. Each summary bit is the OR of one detailed register. Each summary mask bit is the AND of that register's mask, so a register whose bits are all masked shows as masked in the summary. A busy flag is set when a command arrives that cannot run safely while a channel is enabled. Busy appears in every page's summary, always pulls the alert low, and has no mask.

The alert is armed by any newly latched unmasked bit or by a busy event. It is released when the device wins an alert-response-address cycle, and it stays released until the next such event. While armed, the line stays low only as long as some unmasked latched bit, or busy, remains. A read port, steered by a page and register index, returns the selected status register and its mask.

Top module: `alert_agg`

## Requirements
- R1: A set pulse ORs `set_bits_i` into the status register chosen by `set_page_i`/`set_reg_i`, and the read port shows it on the next cycle.
- R2: A status write (`wr_mask_i`=0) clears only the bits written as one. Other bits keep their value.
- R3: Summary word bit r of page p (bit p*4+r) is the OR of register r (0 = voltage, 1 = current, 2 = temperature). Bit p*4+3 is the busy flag.
- R4: Summary mask bit p*4+r is 1 only when every bit of mask register r of page p is 1. Bit p*4+3 (busy) always reads 0.
- R5: A set pulse carrying at least one unmasked bit drives `alert_no` low on the next cycle.
- R6: Bits whose mask is set still latch and appear in the summary, but they do not pull `alert_no` low.
- R7: A busy event sets the busy bit and pulls `alert_no` low, even when every status bit is masked.
- R8: `ara_ok_i` releases `alert_no` high while latched bits remain. A later unmasked set pulse drives it low again.
- R9: `clear_all_i` clears all status bits and busy in one cycle and releases the alert. Masks are kept.
- R10: A set or write aimed at one page leaves the other page unchanged.
- R11: The alert goes high as soon as no unmasked latched bit and no busy remain, whether the last bit was cleared or masked.
- R12: After reset, all status bits, masks and busy are zero and `alert_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_valid_i | input | 1 | Fault-set pulse |
| set_page_i | input | 1 | Page targeted by the set pulse |
| set_reg_i | input | 2 | Register targeted by the set pulse |
| set_bits_i | input | 8 | Bits to latch |
| wr_valid_i | input | 1 | Register write strobe |
| wr_mask_i | input | 1 | 1: write mask register, 0: write-one-to-clear status |
| wr_page_i | input | 1 | Page of the write |
| wr_reg_i | input | 2 | Register of the write |
| wr_data_i | input | 8 | Write data |
| clear_all_i | input | 1 | Clear every latched status bit and busy |
| busy_evt_i | input | 1 | Unsafe command received |
| ara_ok_i | input | 1 | Address sent during alert response |
| rd_page_i | input | 1 | Read page select |
| rd_reg_i | input | 2 | Read register select |
| rd_status_o | output | 8 | Selected status register |
| rd_mask_o | output | 8 | Selected mask register |
| sum_word_o | output | 8 | Per-page summary bits, 4 per page |
| sum_mask_o | output | 8 | Per-page summary mask bits |
| alert_no | output | 1 | Shared alert, active low |

## Verification
The bench drives set pulses into unmasked registers, fully masked registers and partly masked registers. This separates the roll-up of status bits, which uses OR, from the roll-up of masks, which uses AND. It also separates a latched bit that is silent from one that asserts the alert. Busy events are sent with everything masked, to show that busy cannot be masked. Release is tested in three ways: clearing the last bit, masking the last bit, and an alert-response win. These show that the pending condition and the arming are tracked separately. Cross-page reads confirm that page steering keeps the banks apart.

// File: rtl/alert_agg_pkg.sv
package alert_agg_pkg;
  localparam int unsigned DEF_PAGES = 2;
  localparam int unsigned DEF_REGS  = 3;
  localparam int unsigned DEF_REG_W = 8;

  typedef enum logic {
    WR_STATUS = 1'b0,
    WR_MASK   = 1'b1
  } wr_kind_e;
endpackage

// File: rtl/alert_status_bank.sv
module alert_status_bank #(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_en_i,
  input  logic [IDX_W-1:0]    set_reg_i,
  input  logic [REG_W-1:0]    set_bits_i,
  input  logic                wr_en_i,
  input  logic                wr_mask_i,
  input  logic [IDX_W-1:0]    wr_reg_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic                clear_all_i,
  input  logic [IDX_W-1:0]    rd_reg_i,
  output logic [REG_W-1:0]    rd_status_o,
  output logic [REG_W-1:0]    rd_mask_o,
  output logic [NUM_REGS-1:0] sum_bits_o,
  output logic [NUM_REGS-1:0] sum_mask_o,
  output logic                pend_o,
  output logic                event_o
);
  import alert_agg_pkg::*;

  logic [NUM_REGS-1:0][REG_W-1:0] stat_q, mask_q;
  logic [NUM_REGS-1:0]            pend_r, ev_r;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic set_hit, w1c_hit, msk_hit;
    assign set_hit = set_en_i && (set_reg_i == IDX_W'(r));
    assign w1c_hit = wr_en_i && (wr_kind_e'(wr_mask_i) == WR_STATUS) && (wr_reg_i == IDX_W'(r));
    assign msk_hit = wr_en_i && (wr_kind_e'(wr_mask_i) == WR_MASK) && (wr_reg_i == IDX_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q[r] <= '0;
        mask_q[r] <= '0;
      end else begin
        // a fresh fault wins over a same-cycle clear of that bit
        if (clear_all_i) stat_q[r] <= '0;
        else stat_q[r] <= (stat_q[r] & ~(w1c_hit ? wr_data_i : '0))
                        | (set_hit ? set_bits_i : '0);
        if (msk_hit) mask_q[r] <= wr_data_i;
      end
    end

    assign sum_bits_o[r] = |stat_q[r];
    assign sum_mask_o[r] = &mask_q[r];
    assign pend_r[r]     = |(stat_q[r] & ~mask_q[r]);
    assign ev_r[r]       = set_hit && |(set_bits_i & ~mask_q[r]);
  end

  assign pend_o  = |pend_r;
  assign event_o = |ev_r;

  always_comb begin
    rd_status_o = '0;
    rd_mask_o   = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rd_reg_i == IDX_W'(r)) begin
        rd_status_o = stat_q[r];
        rd_mask_o   = mask_q[r];
      end
    end
  end

  p_bank_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_all_i |=> !pend_o);
endmodule

// File: rtl/alert_arbiter.sv
module alert_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic busy_evt_i,
  input  logic ara_i,
  input  logic clear_all_i,
  input  logic pend_i,
  output logic busy_o,
  output logic alert_no
);
  logic busy_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (clear_all_i)     busy_q <= 1'b0;
      else if (busy_evt_i) busy_q <= 1'b1;

      if (clear_all_i)              arm_q <= 1'b0;
      else if (ev_i || busy_evt_i)  arm_q <= 1'b1;
      else if (ara_i)               arm_q <= 1'b0;
    end
  end

  assign busy_o   = busy_q;
  assign alert_no = ~(arm_q & (pend_i | busy_q));

  p_busy_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_evt_i && !clear_all_i |=> !alert_no && busy_o);
  p_ara_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_i && !ev_i && !busy_evt_i && !clear_all_i |=> alert_no);
  p_clear_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_all_i |=> alert_no && !busy_o);
endmodule

// File: rtl/alert_agg.sv
module alert_agg #(
  parameter int unsigned NUM_PAGES = alert_agg_pkg::DEF_PAGES,
  parameter int unsigned NUM_REGS  = alert_agg_pkg::DEF_REGS,
  parameter int unsigned REG_W     = alert_agg_pkg::DEF_REG_W,
  localparam int unsigned PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned SUM_W    = NUM_REGS + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       set_valid_i,
  input  logic [PAGE_W-1:0]          set_page_i,
  input  logic [IDX_W-1:0]           set_reg_i,
  input  logic [REG_W-1:0]           set_bits_i,
  input  logic                       wr_valid_i,
  input  logic                       wr_mask_i,
  input  logic [PAGE_W-1:0]          wr_page_i,
  input  logic [IDX_W-1:0]           wr_reg_i,
  input  logic [REG_W-1:0]           wr_data_i,
  input  logic                       clear_all_i,
  input  logic                       busy_evt_i,
  input  logic                       ara_ok_i,
  input  logic [PAGE_W-1:0]          rd_page_i,
  input  logic [IDX_W-1:0]           rd_reg_i,
  output logic [REG_W-1:0]           rd_status_o,
  output logic [REG_W-1:0]           rd_mask_o,
  output logic [NUM_PAGES*SUM_W-1:0] sum_word_o,
  output logic [NUM_PAGES*SUM_W-1:0] sum_mask_o,
  output logic                       alert_no
);
  logic [NUM_PAGES-1:0][REG_W-1:0]    pg_stat, pg_mask;
  logic [NUM_PAGES-1:0][NUM_REGS-1:0] pg_sum, pg_smask;
  logic [NUM_PAGES-1:0]               pg_pend, pg_ev;
  logic                               busy;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    alert_status_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_en_i    (set_valid_i && (set_page_i == PAGE_W'(p))),
      .set_reg_i   (set_reg_i),
      .set_bits_i  (set_bits_i),
      .wr_en_i     (wr_valid_i && (wr_page_i == PAGE_W'(p))),
      .wr_mask_i   (wr_mask_i),
      .wr_reg_i    (wr_reg_i),
      .wr_data_i   (wr_data_i),
      .clear_all_i (clear_all_i),
      .rd_reg_i    (rd_reg_i),
      .rd_status_o (pg_stat[p]),
      .rd_mask_o   (pg_mask[p]),
      .sum_bits_o  (pg_sum[p]),
      .sum_mask_o  (pg_smask[p]),
      .pend_o      (pg_pend[p]),
      .event_o     (pg_ev[p])
    );
    // busy sits above the per-register bits and is never maskable
    assign sum_word_o[p*SUM_W +: SUM_W] = {busy, pg_sum[p]};
    assign sum_mask_o[p*SUM_W +: SUM_W] = {1'b0, pg_smask[p]};
  end

  always_comb begin
    rd_status_o = '0;
    rd_mask_o   = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (rd_page_i == PAGE_W'(p)) begin
        rd_status_o = pg_stat[p];
        rd_mask_o   = pg_mask[p];
      end
    end
  end

  alert_arbiter u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (|pg_ev),
    .busy_evt_i  (busy_evt_i),
    .ara_i       (ara_ok_i),
    .clear_all_i (clear_all_i),
    .pend_i      (|pg_pend),
    .busy_o      (busy),
    .alert_no    (alert_no)
  );

  p_event_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pg_ev) && !clear_all_i && !wr_valid_i |=> !alert_no);
  p_masked_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alert_no |-> ((|pg_pend) || busy));
endmodule

// File: tb/alert_agg_test.sv
module alert_agg_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       set_valid_i = 0, set_page_i = 0, wr_valid_i = 0, wr_mask_i = 0, wr_page_i = 0;
  logic [1:0] set_reg_i = 0, wr_reg_i = 0, rd_reg_i = 0;
  logic [7:0] set_bits_i = 0, wr_data_i = 0;
  logic       clear_all_i = 0, busy_evt_i = 0, ara_ok_i = 0, rd_page_i = 0;
  logic [7:0] rd_status_o, rd_mask_o, sum_word_o, sum_mask_o;
  logic       alert_no;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  alert_agg uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .set_valid_i(set_valid_i), .set_page_i(set_page_i), .set_reg_i(set_reg_i), .set_bits_i(set_bits_i),
    .wr_valid_i(wr_valid_i), .wr_mask_i(wr_mask_i), .wr_page_i(wr_page_i), .wr_reg_i(wr_reg_i),
    .wr_data_i(wr_data_i), .clear_all_i(clear_all_i), .busy_evt_i(busy_evt_i), .ara_ok_i(ara_ok_i),
    .rd_page_i(rd_page_i), .rd_reg_i(rd_reg_i), .rd_status_o(rd_status_o), .rd_mask_o(rd_mask_o),
    .sum_word_o(sum_word_o), .sum_mask_o(sum_mask_o), .alert_no(alert_no)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic pg, input logic [1:0] r);
    rd_page_i = pg; rd_reg_i = r; #1;
  endtask

  task automatic do_set(input logic pg, input logic [1:0] r, input logic [7:0] b);
    @(negedge clk); set_valid_i = 1; set_page_i = pg; set_reg_i = r; set_bits_i = b;
    @(negedge clk); set_valid_i = 0;
  endtask

  task automatic do_wr(input logic msk, input logic pg, input logic [1:0] r, input logic [7:0] d);
    @(negedge clk); wr_valid_i = 1; wr_mask_i = msk; wr_page_i = pg; wr_reg_i = r; wr_data_i = d;
    @(negedge clk); wr_valid_i = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear_all_i = 1; @(negedge clk); clear_all_i = 0;
  endtask
  task automatic pulse_busy();
    @(negedge clk); busy_evt_i = 1; @(negedge clk); busy_evt_i = 0;
  endtask
  task automatic pulse_ara();
    @(negedge clk); ara_ok_i = 1; @(negedge clk); ara_ok_i = 0;
  endtask

  task automatic t_reset();
    check("R12 alert", {7'd0, alert_no}, 8'h01);
    check("R12 sum_word", sum_word_o, 8'h00);
    check("R12 sum_mask", sum_mask_o, 8'h00);
    rd(1, 2); check("R12 mask", rd_mask_o, 8'h00);
  endtask

  task automatic t_set_w1c();
    do_set(0, 0, 8'h05);
    rd(0, 0); check("R1 status", rd_status_o, 8'h05);
    check("R3 sum_word", sum_word_o, 8'h01);
    check("R5 alert", {7'd0, alert_no}, 8'h00);
    rd(1, 0); check("R10 other page", rd_status_o, 8'h00);
    do_wr(0, 0, 0, 8'h04);
    rd(0, 0); check("R2 w1c partial", rd_status_o, 8'h01);
    check("R11 still low", {7'd0, alert_no}, 8'h00);
    do_wr(0, 0, 0, 8'h01);
    rd(0, 0); check("R2 w1c last", rd_status_o, 8'h00);
    check("R11 released", {7'd0, alert_no}, 8'h01);
  endtask

  task automatic t_mask();
    do_wr(1, 1, 1, 8'h7F);
    check("R4 partial mask", sum_mask_o, 8'h00);
    do_wr(1, 1, 1, 8'hFF);
    check("R4 full mask", sum_mask_o, 8'h20);
    rd(0, 1); check("R10 mask other page", rd_mask_o, 8'h00);
    do_set(1, 1, 8'h10);
    rd(1, 1); check("R6 latched", rd_status_o, 8'h10);
    check("R6 summary", sum_word_o, 8'h20);
    check("R6 alert quiet", {7'd0, alert_no}, 8'h01);
  endtask

  task automatic t_busy();
    pulse_busy();
    check("R7 busy summary", sum_word_o, 8'hA8);
    check("R7 alert", {7'd0, alert_no}, 8'h00);
    check("R4 busy unmaskable", sum_mask_o & 8'h88, 8'h00);
    pulse_clear();
    check("R9 cleared", sum_word_o, 8'h00);
    check("R9 alert", {7'd0, alert_no}, 8'h01);
    rd(1, 1); check("R9 mask kept", rd_mask_o, 8'hFF);
  endtask

  task automatic t_ara();
    do_set(1, 2, 8'h80);
    check("R5 alert p1", {7'd0, alert_no}, 8'h00);
    pulse_ara();
    check("R8 released", {7'd0, alert_no}, 8'h01);
    rd(1, 2); check("R8 bits kept", rd_status_o, 8'h80);
    do_set(0, 1, 8'h02);
    check("R8 rearmed", {7'd0, alert_no}, 8'h00);
    pulse_clear();
    check("R9 all clear", sum_word_o, 8'h00);
  endtask

  task automatic t_mask_release();
    do_set(0, 2, 8'h01);
    check("R5 alert p0r2", {7'd0, alert_no}, 8'h00);
    do_wr(1, 0, 2, 8'h01);
    check("R11 masked release", {7'd0, alert_no}, 8'h01);
    check("R6 summary stays", sum_word_o, 8'h04);
  endtask

  initial begin
    #1; t_reset();
    #10; rst_ni = 1;
    t_set_w1c();
    t_mask();
    t_busy();
    t_ara();
    t_mask_release();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule